// File: doc/BRIEF.md
# Scalar Immediate-Operand Execution Unit

This block executes scalar instructions whose second operand is a 16-bit immediate taken from the instruction word. Each cycle in which `in_valid` is high, it takes one 32-bit word. It checks the encoding field and decodes the opcode under one of two generation-dependent opcode numberings, chosen by `map_sel`. It then carries out a move, a conditional move, one of twelve compares, an add or a multiply.

The operands are a 128-entry file of 32-bit scalar registers, addressed by the 7-bit destination field, and a one-bit scalar condition flag. All results commit on the clock edge after the word is presented. At that edge one of three one-cycle flags is raised: done, illegal or unsupported. A combinational debug port reads any register, so a surrounding test or the pipeline can observe the file.

Instruction word layout:
- Bits 31:28 hold the encoding type.
- Bits 27:23 hold the opcode.
- Bits 22:16 hold the destination register index.
- Bits 15:0 hold the immediate.

Top module: `simm_exec_unit`

## Requirements
- R1: A valid word whose bits 31:28 differ from 4'b1011 raises `illegal` for one cycle and changes no register and not `scc`.
- R2: With `map_sel`=0, opcodes decode as follows: 0 is move, 2 is conditional move, 3..8 are signed compares, 9..14 are unsigned compares, 15 is add and 16 is multiply. Opcode 1 and opcodes 22..31 are illegal. With `map_sel`=1: 0 is move, 1 is conditional move, 2..7 are signed compares, 8..13 are unsigned compares, 14 is add and 15 is multiply. Opcodes 21..31 are illegal. Illegal opcodes behave as in R1.
- R3: Move writes the sign-extended immediate (bits 15:0) to the destination register and leaves `scc` unchanged.
- R4: Conditional move writes the sign-extended immediate to the destination only when `scc` is 1; `scc` never changes.
- R5: Signed compares treat the register as a signed 32-bit value and compare it with the sign-extended immediate. Within each compare group the relations run, in opcode order: equal, not equal, greater, greater-or-equal, less, less-or-equal. `scc` becomes 1 when the relation holds and 0 when it does not. The register is not written.
- R6: Unsigned compares use the same relation order as R5. They treat the register as unsigned and compare it with the zero-extended immediate, then write the result to `scc` only.
- R7: Add writes register plus sign-extended immediate, wrapped to 32 bits. It sets `scc` to 1 exactly when the true sum lies outside -2^31..2^31-1.
- R8: Multiply writes the low 32 bits of register times the sign-extended immediate and leaves `scc` unchanged.
- R9: Opcodes 17..21 (`map_sel`=0) and 16..20 (`map_sel`=1) raise `unsupported` for one cycle and change no state.
- R10: Register and `scc` updates and the `done` pulse appear on the clock edge after the valid word. No flag rises and `scc` holds in a cycle after one without `in_valid`.
- R11: Reset clears all registers, `scc` and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word |
| map_sel | input | 1 | Opcode numbering: 0 older, 1 newer |
| dbg_addr | input | 7 | Debug read register index |
| dbg_data | output | 32 | Debug read data (combinational) |
| done | output | 1 | Legal supported instruction executed |
| illegal | output | 1 | Bad encoding or unassigned opcode |
| unsupported | output | 1 | Opcode outside this unit's scope |
| scc | output | 1 | Scalar condition flag |

## Verification
Every result is due exactly one rising edge after the word is sampled. This covers the flags, `scc` and the destination register as seen on the debug port. The bench drives a word on a falling edge and waits one rising edge. On the next falling edge it drops `in_valid`, points `dbg_addr` at the destination and compares against its reference model. The checker asserts that a cycle without `in_valid` is followed by no flag and a stable `scc`. It also asserts the one-edge response for bad encodings, unsupported opcodes and moves.

// File: rtl/sik_pkg.sv
package sik_pkg;
  localparam int WORD_W   = 32;
  localparam int IMM_W    = 16;
  localparam int DST_W    = 7;
  localparam int OPC_W    = 5;
  localparam int ENC_W    = 4;
  localparam int NUM_REGS = 1 << DST_W;
  localparam logic [ENC_W-1:0] ENC_OK = 4'b1011;

  typedef enum logic [2:0] {
    K_MOV, K_CMOV, K_CMP, K_ADD, K_MUL, K_UNSUP, K_ILL
  } kind_e;

  typedef enum logic [2:0] {
    REL_EQ, REL_NE, REL_GT, REL_GE, REL_LT, REL_LE
  } rel_e;

  typedef struct packed {
    kind_e kind;
    rel_e  rel;
    logic  sgn;
  } dec_t;
endpackage

// File: rtl/sik_decode.sv
module sik_decode
  import sik_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              map_sel,
  output dec_t              dec
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] idx;
  logic [OPC_W-1:0] rel_idx;
  logic             gap;

  assign opc = word[WORD_W-ENC_W-1 -: OPC_W];

  // Fold the older numbering onto the newer one: it only has a hole at 1.
  always_comb begin
    idx = opc;
    gap = 1'b0;
    if (!map_sel) begin
      if (opc == OPC_W'(1))      gap = 1'b1;
      else if (opc != '0)        idx = opc - OPC_W'(1);
    end
  end

  assign rel_idx = (idx < OPC_W'(8)) ? idx - OPC_W'(2) : idx - OPC_W'(8);

  always_comb begin
    dec.rel = rel_e'(rel_idx[2:0]);
    dec.sgn = (idx < OPC_W'(8));
    if (word[WORD_W-1 -: ENC_W] != ENC_OK || gap) dec.kind = K_ILL;
    else if (idx == OPC_W'(0))                    dec.kind = K_MOV;
    else if (idx == OPC_W'(1))                    dec.kind = K_CMOV;
    else if (idx <= OPC_W'(13))                   dec.kind = K_CMP;
    else if (idx == OPC_W'(14))                   dec.kind = K_ADD;
    else if (idx == OPC_W'(15))                   dec.kind = K_MUL;
    else if (idx <= OPC_W'(20))                   dec.kind = K_UNSUP;
    else                                          dec.kind = K_ILL;
  end
endmodule

// File: rtl/sik_alu.sv
module sik_alu
  import sik_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dec_t              dec,
  input  logic [DATA_W-1:0] src,
  input  logic [IMM_W-1:0]  imm,
  input  logic              scc_in,
  output logic              wr_reg,
  output logic              wr_scc,
  output logic [DATA_W-1:0] res,
  output logic              scc_out
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_s, imm_z, opnd, sum, prod;
  logic              eq, lt, ovf, rel_hit;

  assign imm_s = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_z = {{EXT_W{1'b0}}, imm};
  assign opnd  = dec.sgn ? imm_s : imm_z;
  assign eq    = (src == opnd);
  assign lt    = dec.sgn ? ($signed(src) < $signed(opnd)) : (src < opnd);
  assign sum   = src + imm_s;
  assign prod  = src * imm_s;
  assign ovf   = (src[DATA_W-1] == imm_s[DATA_W-1]) && (sum[DATA_W-1] != src[DATA_W-1]);

  always_comb begin
    unique case (dec.rel)
      REL_EQ:  rel_hit = eq;
      REL_NE:  rel_hit = !eq;
      REL_GT:  rel_hit = !lt && !eq;
      REL_GE:  rel_hit = !lt;
      REL_LT:  rel_hit = lt;
      REL_LE:  rel_hit = lt || eq;
      default: rel_hit = 1'b0;
    endcase
  end

  always_comb begin
    wr_reg  = 1'b0;
    wr_scc  = 1'b0;
    res     = imm_s;
    scc_out = scc_in;
    case (dec.kind)
      K_MOV:  wr_reg = 1'b1;
      K_CMOV: wr_reg = scc_in;
      K_CMP:  begin wr_scc = 1'b1; scc_out = rel_hit; end
      K_ADD:  begin wr_reg = 1'b1; wr_scc = 1'b1; res = sum; scc_out = ovf; end
      K_MUL:  begin wr_reg = 1'b1; res = prod; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sik_regfile.sv
module sik_regfile
  import sik_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DST_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DST_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [DST_W-1:0]  daddr,
  output logic [DATA_W-1:0] ddata
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];

  always_comb begin
    regs_d = regs_q;
    if (we) regs_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '{default: '0};
    else        regs_q <= regs_d;
  end

  assign rdata = regs_q[raddr];
  assign ddata = regs_q[daddr];
endmodule

// File: rtl/simm_exec_unit.sv
module simm_exec_unit
  import sik_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  input  logic              map_sel,
  input  logic [6:0]        dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              done,
  output logic              illegal,
  output logic              unsupported,
  output logic              scc
);
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  dec_t              dec;
  logic [DST_W-1:0]  dst;
  logic [DATA_W-1:0] src, res;
  logic              wr_reg, wr_scc, scc_new, go, we;
  logic              scc_d, done_d, ill_d, uns_d;

  assign dst = in_word[IMM_W +: DST_W];

  sik_decode u_dec (.word(in_word), .map_sel(map_sel), .dec(dec));

  sik_alu #(.DATA_W(DATA_W)) u_alu (
    .dec(dec), .src(src), .imm(in_word[IMM_W-1:0]), .scc_in(scc),
    .wr_reg(wr_reg), .wr_scc(wr_scc), .res(res), .scc_out(scc_new)
  );

  assign go = in_valid && (dec.kind != K_ILL) && (dec.kind != K_UNSUP);
  assign we = go && wr_reg;

  sik_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_ok), .we(we), .waddr(dst), .wdata(res),
    .raddr(dst), .rdata(src), .daddr(dbg_addr), .ddata(dbg_data)
  );

  always_comb begin
    scc_d  = (go && wr_scc) ? scc_new : scc;
    done_d = go;
    ill_d  = in_valid && (dec.kind == K_ILL);
    uns_d  = in_valid && (dec.kind == K_UNSUP);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      scc         <= 1'b0;
      done        <= 1'b0;
      illegal     <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      scc         <= scc_d;
      done        <= done_d;
      illegal     <= ill_d;
      unsupported <= uns_d;
    end
  end
endmodule

// File: rtl/simm_exec_unit_chk.sv
module simm_exec_unit_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        map_sel,
  input logic        done,
  input logic        illegal,
  input logic        unsupported,
  input logic        scc
);
  logic enc_ok;
  assign enc_ok = (in_word[31:28] == 4'b1011);

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({done, illegal, unsupported})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !(done || illegal || unsupported) && $stable(scc)); // R10

  AST_BAD_ENC: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && !enc_ok |=> illegal && $stable(scc)); // R1

  AST_OLD_GAP: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && enc_ok && !map_sel && in_word[27:23] == 5'd1 |=> illegal); // R2

  AST_MOVE_KEEPS_SCC: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && enc_ok && in_word[27:23] == 5'd0 |=> done && $stable(scc)); // R3

  AST_NEW_UNSUP: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && enc_ok && map_sel && in_word[27:23] >= 5'd16 && in_word[27:23] <= 5'd20
    |=> unsupported && $stable(scc)); // R9
endmodule

bind simm_exec_unit simm_exec_unit_chk u_chk (
  .clk(clk), .rst_ok(rst_ok), .in_valid(in_valid), .in_word(in_word),
  .map_sel(map_sel), .done(done), .illegal(illegal),
  .unsupported(unsupported), .scc(scc)
);

// File: tb/simm_exec_unit_test.sv
module simm_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        map_sel;
  logic [6:0]  dbg_addr;
  logic [31:0] dbg_data;
  logic        done, illegal, unsupported, scc;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_regs [128];
  logic        m_scc;

  simm_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .map_sel(map_sel), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .done(done), .illegal(illegal), .unsupported(unsupported), .scc(scc)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 mov 1 cmov 2 cmp 3 add 4 mul 5 unsup 6 illegal
  function automatic void classify(input logic [31:0] w, input logic mp,
                                   output int kind, output int rel, output bit sgn);
    int op = int'(w[27:23]);
    rel = 0; sgn = 1'b0;
    if (w[31:28] != 4'b1011) begin kind = 6; return; end
    if (!mp) begin
      if (op == 0) kind = 0;
      else if (op == 2) kind = 1;
      else if (op >= 3 && op <= 8)   begin kind = 2; rel = op - 3; sgn = 1'b1; end
      else if (op >= 9 && op <= 14)  begin kind = 2; rel = op - 9; end
      else if (op == 15) kind = 3;
      else if (op == 16) kind = 4;
      else if (op >= 17 && op <= 21) kind = 5;
      else kind = 6;
    end else begin
      if (op == 0) kind = 0;
      else if (op == 1) kind = 1;
      else if (op >= 2 && op <= 7)   begin kind = 2; rel = op - 2; sgn = 1'b1; end
      else if (op >= 8 && op <= 13)  begin kind = 2; rel = op - 8; end
      else if (op == 14) kind = 3;
      else if (op == 15) kind = 4;
      else if (op >= 16 && op <= 20) kind = 5;
      else kind = 6;
    end
  endfunction

  task automatic issue(input logic [31:0] w, input logic mp);
    int kind, rel; bit sgn;
    logic [6:0]  d = w[22:16];
    logic [31:0] r, is, iz;
    longint      a, b, t;
    logic [63:0] p;
    bit          hit;
    string       tag;
    classify(w, mp, kind, rel, sgn);
    r  = m_regs[d];
    is = {{16{w[15]}}, w[15:0]};
    iz = {16'h0, w[15:0]};
    case (kind)
      0: begin tag = "R3"; m_regs[d] = is; end
      1: begin tag = "R4"; if (m_scc) m_regs[d] = is; end
      2: begin
        tag = sgn ? "R5" : "R6";
        if (sgn) begin a = longint'($signed(r)); b = longint'($signed(is)); end
        else     begin a = longint'({32'h0, r}); b = longint'({32'h0, iz}); end
        case (rel)
          0: hit = (a == b);  1: hit = (a != b);
          2: hit = (a > b);   3: hit = (a >= b);
          4: hit = (a < b);   default: hit = (a <= b);
        endcase
        m_scc = hit;
      end
      3: begin
        tag = "R7";
        t = longint'($signed(r)) + longint'($signed(is));
        m_regs[d] = r + is;
        m_scc = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      4: begin tag = "R8"; p = r * is; m_regs[d] = p[31:0]; end
      5: tag = "R9";
      default: tag = (w[31:28] != 4'b1011) ? "R1" : "R2";
    endcase
    @(negedge clk);
    in_valid = 1'b1; in_word = w; map_sel = mp;
    @(negedge clk);
    in_valid = 1'b0; dbg_addr = d;
    #1;
    check({tag, " done"},  {31'h0, done},        {31'h0, kind <= 4});
    check({tag, " illeg"}, {31'h0, illegal},     {31'h0, kind == 6});
    check({tag, " unsup"}, {31'h0, unsupported}, {31'h0, kind == 5});
    check({tag, " scc"},   {31'h0, scc},         {31'h0, m_scc});
    check({tag, " reg"},   dbg_data,             m_regs[d]);
  endtask

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [6:0] d, input logic [15:0] imm);
    return {4'b1011, op, d, imm};
  endfunction

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; map_sel = 1'b0; dbg_addr = '0;
    foreach (m_regs[i]) m_regs[i] = '0;
    m_scc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check("R11 scc", {31'h0, scc}, 32'h0);
    check("R11 flags", {29'h0, done, illegal, unsupported}, 32'h0);
    dbg_addr = 7'd127; #1; check("R11 reg127", dbg_data, 32'h0);
    dbg_addr = 7'd0;   #1; check("R11 reg0", dbg_data, 32'h0);

    // directed corners
    issue(mk(5'd0, 7'd5, 16'h8000), 1'b1);     // R3 move sign-extend
    issue(mk(5'd0, 7'd1, 16'hFFFF), 1'b0);
    issue(mk(5'd8, 7'd1, 16'hFFFF), 1'b1);     // R6 unsigned eq: 0xFFFFFFFF vs 0x0000FFFF
    issue(mk(5'd2, 7'd1, 16'hFFFF), 1'b1);     // R5 signed eq -> 1
    issue(mk(5'd1, 7'd2, 16'h1234), 1'b1);     // R4 cmov taken
    issue(mk(5'd5, 7'd2, 16'h0001), 1'b0);     // R5 GT signed
    issue(mk(5'd0, 7'd3, 16'h7FFF), 1'b0);
    issue(mk(5'd16, 7'd3, 16'h7FFF), 1'b0);    // R8 mul
    issue(mk(5'd16, 7'd3, 16'h0002), 1'b0);
    issue(mk(5'd15, 7'd3, 16'h7FFF), 1'b0);    // R7 add
    issue(mk(5'd0, 7'd4, 16'h0000), 1'b1);
    issue(mk(5'd14, 7'd4, 16'hFFFF), 1'b1);    // R7 0 + -1
    issue(mk(5'd15, 7'd4, 16'h8000), 1'b1);    // R8 -1 * -32768
    issue(mk(5'd14, 7'd4, 16'h7FFF), 1'b1);
    issue(mk(5'd1, 7'd6, 16'h4321), 1'b1);     // R4 cmov with scc 0 -> no write
    issue({4'b0111, 5'd0, 7'd4, 16'h5555}, 1'b1); // R1
    issue(mk(5'd1, 7'd4, 16'h5555), 1'b0);     // R2 gap in older map
    issue(mk(5'd21, 7'd4, 16'h5555), 1'b1);    // R2 unassigned in newer map
    issue(mk(5'd17, 7'd4, 16'h5555), 1'b0);    // R9
    issue(mk(5'd20, 7'd4, 16'h5555), 1'b1);    // R9
    // overflow edges, R7
    issue(mk(5'd0, 7'd7, 16'h0001), 1'b1);
    for (int k = 0; k < 31; k++) issue(mk(5'd14, 7'd7, 16'h0000), 1'b1);
    issue(mk(5'd15, 7'd7, 16'h4000), 1'b1);    // 1*16384 -> build large value
    issue(mk(5'd15, 7'd7, 16'h4000), 1'b1);    // 2^28
    issue(mk(5'd15, 7'd7, 16'h0008), 1'b1);    // 2^31 wraps to 0x80000000
    issue(mk(5'd14, 7'd7, 16'hFFFF), 1'b1);    // 0x80000000 + -1 -> overflow
    issue(mk(5'd14, 7'd7, 16'h0001), 1'b1);    // 0x7FFFFFFF + 1 -> overflow

    // R10 idle cycles: nothing changes
    repeat (4) @(negedge clk);
    #1;
    check("R10 idle flags", {29'h0, done, illegal, unsupported}, 32'h0);
    check("R10 idle scc", {31'h0, scc}, {31'h0, m_scc});

    // constrained random
    for (int k = 0; k < 600; k++) begin
      logic [31:0] w;
      logic [15:0] imm;
      logic [3:0]  enc;
      case ($urandom % 5)
        0: imm = 16'hFFFF;
        1: imm = 16'h8000;
        2: imm = 16'h7FFF;
        3: imm = 16'($urandom % 8);
        default: imm = 16'($urandom);
      endcase
      enc = ($urandom % 10 == 0) ? 4'($urandom) : 4'b1011;
      w = {enc, 5'($urandom % 24), 7'($urandom % 8), imm};
      issue(w, 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule